// File: doc/BRIEF.md
# Flash Lock-Bit Command Decoder with Status Register

This block models the device side of a flash part's command interface, limited to lock-bit setting. It decodes bus writes. A two-write sequence locks an addressed block or the whole-device master lock. The first write is the setup byte 60h and the second is a confirm byte, written with the block address. After a valid confirm, a busy window whose length comes from a programmable cycle count runs. When the window ends, the lock array is updated or an error is recorded.

Reads return either the status register or the array data presented on an input, depending on the current read mode. Error flags are sticky. They collect across any number of operations, so software can run several lock commands and check the status once at the end. Only a dedicated clear command removes them.

Two inputs can block a lock operation. A voltage-ok flag that is low blocks every lock. A protect pin that is high blocks block locks when the master lock is set. Both inputs are sampled on the confirm write.

Top module: `flash_lock_ctl`

## Requirements
- R1: After reset, reads come from the array input, a status read returns 80h, and all block lock bits and the master lock are clear.
- R2: Writing 60h and then 01h sets the lock bit of the block selected by the low address bits of the confirm write. Writing 60h and then F1h sets the master lock. Lock bits are never cleared except by reset.
- R3: After a valid confirm, status bit 7 reads 0 for max(busyLen,1) cycles and then reads 1. Writes made during that window are ignored.
- R4: A byte other than 01h or F1h following 60h sets status bits 5 and 4 together. It changes no lock bit and starts no busy window.
- R5: If the voltage-ok flag is low at the confirm write, status bits 3 and 4 are set and the lock bits stay unchanged.
- R6: If a block lock is confirmed while the master lock is set and the protect pin is high, status bits 1 and 4 are set and the block stays unlocked. With the protect pin low, the lock succeeds.
- R7: Status bits 5, 4, 3 and 1 stay set through later operations, including successful ones. Writing 50h clears them.
- R8: Writing FFh makes reads return the array input. Writing 70h makes reads return the status register.
- R9: Any command byte other than 60h, 50h, 70h or FFh written in idle sets status bits 5 and 4 and switches reads to status.
- R10: After 60h, and through and after the lock operation, reads return the status register until FFh is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe, one cycle per write |
| wrAddr | input | ADDR_W | Write address; low bits select the block |
| wrData | input | 8 | Command or confirm byte |
| busyLen | input | CNT_W | Busy window length in cycles (0 acts as 1) |
| vppOk | input | 1 | Programming voltage in range |
| protHigh | input | 1 | Level of the reset/protect pin (1 = high) |
| arrayIn | input | 8 | Array data returned in array read mode |
| rdData | output | 8 | Read data: status or array input |
| lockBits | output | NUM_BLOCKS | Per-block lock bits |
| masterLock | output | 1 | Master lock bit |

## Verification
A wrong sequencer state shows at the ports within one cycle of the write that exposes it. A stuck busy state holds bit 7 low past the programmed count. A state that skips setup turns the confirm byte into an unknown command, which sets bits 5 and 4 at once. Bad sticky-flag or pending-condition storage stays hidden until the next status read after an operation completes. For that reason the vectors read status after every operation and check accumulated flags across operations before any clear.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;
  localparam logic [7:0] CMD_LOCK_SETUP  = 8'h60;
  localparam logic [7:0] CMD_CONF_BLOCK  = 8'h01;
  localparam logic [7:0] CMD_CONF_MASTER = 8'hF1;
  localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
  localparam logic [7:0] CMD_RD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_RD_ARRAY    = 8'hFF;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_BUSY  = 2'd2
  } ctlState_t;

  typedef struct packed {
    logic arm;        // valid confirm: capture operands
    logic armMaster;  // the confirm targets the master lock
    logic commit;     // busy window ends this cycle
    logic seqErr;     // command sequence error
    logic clrStat;    // clear sticky flags
    logic showStatus; // read mux selects status
  } ctlStrobe_t;
endpackage

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
  import flash_lock_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  input  logic [CNT_W-1:0] busyLen,
  output ctlStrobe_t       strobe,
  output logic             busy
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  ctlState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             statusMode;
  logic             wrIdle, wrSetup, isConf, isKnown;

  assign wrIdle  = wrEn && (state == ST_IDLE);
  assign wrSetup = wrEn && (state == ST_SETUP);
  assign isConf  = (wrData == CMD_CONF_BLOCK) || (wrData == CMD_CONF_MASTER);
  assign isKnown = (wrData == CMD_LOCK_SETUP) || (wrData == CMD_CLR_STATUS) ||
                   (wrData == CMD_RD_STATUS)  || (wrData == CMD_RD_ARRAY);
  assign busy    = (state == ST_BUSY);

  always_comb begin
    strobe            = '0;
    strobe.arm        = wrSetup && isConf;
    strobe.armMaster  = wrSetup && (wrData == CMD_CONF_MASTER);
    strobe.commit     = busy && (cnt == CNT_ONE);
    strobe.seqErr     = (wrSetup && !isConf) || (wrIdle && !isKnown);
    strobe.clrStat    = wrIdle && (wrData == CMD_CLR_STATUS);
    strobe.showStatus = statusMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      statusMode <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (wrEn) begin
          case (wrData)
            CMD_LOCK_SETUP: begin
              state      <= ST_SETUP;
              statusMode <= 1'b1;
            end
            CMD_CLR_STATUS: ;
            CMD_RD_ARRAY:   statusMode <= 1'b0;
            default:        statusMode <= 1'b1;
          endcase
        end
        ST_SETUP: if (wrEn) begin
          if (isConf) begin
            state <= ST_BUSY;
            cnt   <= (busyLen == '0) ? CNT_ONE : busyLen;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_BUSY: begin
          if (cnt == CNT_ONE) state <= ST_IDLE;
          else                cnt   <= cnt - CNT_ONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_busy_shows_status_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> statusMode);

  assert_busy_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt != CNT_ONE) |=> busy);

  assert_busy_ends_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt == CNT_ONE) |=> (state == ST_IDLE));

  assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.arm, strobe.seqErr, strobe.clrStat, strobe.commit}));
endmodule

// File: rtl/flash_lock_dp.sv
module flash_lock_dp
  import flash_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  parameter int BLK_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobe_t            strobe,
  input  logic [BLK_W-1:0]      blkSel,
  input  logic                  vppOk,
  input  logic                  protHigh,
  input  logic                  busy,
  input  logic [7:0]            arrayIn,
  output logic [7:0]            rdData,
  output logic [NUM_BLOCKS-1:0] lockBits,
  output logic                  masterLock
);
  logic [BLK_W-1:0] pendBlk;
  logic pendMaster, pendVpp, pendProt;
  logic flagSeq, flagOp, flagVpp, flagProt;
  logic failVpp, failProt, doLock;
  logic [7:0] statusWord;

  assign failVpp  = strobe.commit && !pendVpp;
  assign failProt = strobe.commit && pendVpp && !pendMaster && masterLock && pendProt;
  assign doLock   = strobe.commit && !failVpp && !failProt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendBlk    <= '0;
      pendMaster <= 1'b0;
      pendVpp    <= 1'b0;
      pendProt   <= 1'b0;
    end else if (strobe.arm) begin
      pendBlk    <= blkSel;
      pendMaster <= strobe.armMaster;
      pendVpp    <= vppOk;
      pendProt   <= protHigh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagSeq  <= 1'b0;
      flagOp   <= 1'b0;
      flagVpp  <= 1'b0;
      flagProt <= 1'b0;
    end else if (strobe.clrStat) begin
      flagSeq  <= 1'b0;
      flagOp   <= 1'b0;
      flagVpp  <= 1'b0;
      flagProt <= 1'b0;
    end else begin
      if (strobe.seqErr) begin
        flagSeq <= 1'b1;
        flagOp  <= 1'b1;
      end
      if (failVpp) begin
        flagVpp <= 1'b1;
        flagOp  <= 1'b1;
      end
      if (failProt) begin
        flagProt <= 1'b1;
        flagOp   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                     masterLock <= 1'b0;
    else if (doLock && pendMaster) masterLock <= 1'b1;
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_lock
    always_ff @(posedge clk) begin
      if (!rstN)
        lockBits[b] <= 1'b0;
      else if (doLock && !pendMaster && (pendBlk == BLK_W'(b)))
        lockBits[b] <= 1'b1;
    end

    assert_lock_never_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
      lockBits[b] |=> lockBits[b]);
  end

  assign statusWord = {~busy, 1'b0, flagSeq, flagOp, flagVpp, 1'b0, flagProt, 1'b0};
  assign rdData     = strobe.showStatus ? statusWord : arrayIn;

  assert_seq_pair_R4: assert property (@(posedge clk) disable iff (!rstN)
    flagSeq |-> flagOp);

  assert_sticky_op_R7: assert property (@(posedge clk) disable iff (!rstN)
    (flagOp && !strobe.clrStat) |=> flagOp);

  assert_sticky_vpp_R7: assert property (@(posedge clk) disable iff (!rstN)
    (flagVpp && !strobe.clrStat) |=> flagVpp);

  assert_sticky_prot_R7: assert property (@(posedge clk) disable iff (!rstN)
    (flagProt && !strobe.clrStat) |=> flagProt);

  assert_vpp_fail_keeps_R5: assert property (@(posedge clk) disable iff (!rstN)
    failVpp |=> ($stable(lockBits) && $stable(masterLock) && flagVpp));

  assert_prot_fail_keeps_R6: assert property (@(posedge clk) disable iff (!rstN)
    failProt |=> ($stable(lockBits) && flagProt));
endmodule

// File: rtl/flash_lock_ctl.sv
module flash_lock_ctl
  import flash_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [7:0]            wrData,
  input  logic [CNT_W-1:0]      busyLen,
  input  logic                  vppOk,
  input  logic                  protHigh,
  input  logic [7:0]            arrayIn,
  output logic [7:0]            rdData,
  output logic [NUM_BLOCKS-1:0] lockBits,
  output logic                  masterLock
);
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;

  ctlStrobe_t strobe;
  logic       busy;

  flash_lock_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .busyLen(busyLen),
    .strobe (strobe),
    .busy   (busy)
  );

  flash_lock_dp #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .blkSel    (wrAddr[BLK_W-1:0]),
    .vppOk     (vppOk),
    .protHigh  (protHigh),
    .busy      (busy),
    .arrayIn   (arrayIn),
    .rdData    (rdData),
    .lockBits  (lockBits),
    .masterLock(masterLock)
  );
endmodule

// File: tb/flash_lock_ctl_bench.sv
module flash_lock_ctl_bench;
  logic       clk = 1'b0;
  logic       rstN;
  logic       wrEn;
  logic [7:0] wrAddr;
  logic [7:0] wrData;
  logic [7:0] busyLen;
  logic       vppOk, protHigh;
  logic [7:0] arrayIn;
  logic [7:0] rdData;
  logic [3:0] lockBits;
  logic       masterLock;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  flash_lock_ctl u_flash_lock_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .busyLen(busyLen), .vppOk(vppOk), .protHigh(protHigh), .arrayIn(arrayIn),
    .rdData(rdData), .lockBits(lockBits), .masterLock(masterLock)
  );

  // fields: [25] clear first, [24:17] confirm, [16:15] block, [14] vpp, [13] protect,
  //         [12:5] expected status, [4:1] expected locks, [0] expected master
  localparam logic [25:0] VEC [8] = '{
    {1'b0, 8'h01, 2'd1, 1'b1, 1'b1, 8'h80, 4'b0010, 1'b0},
    {1'b0, 8'h01, 2'd3, 1'b0, 1'b0, 8'h98, 4'b0010, 1'b0},
    {1'b0, 8'h01, 2'd0, 1'b1, 1'b0, 8'h98, 4'b0011, 1'b0},
    {1'b1, 8'hF1, 2'd0, 1'b1, 1'b0, 8'h80, 4'b0011, 1'b1},
    {1'b0, 8'h01, 2'd2, 1'b1, 1'b1, 8'h92, 4'b0011, 1'b1},
    {1'b1, 8'h01, 2'd2, 1'b1, 1'b0, 8'h80, 4'b0111, 1'b1},
    {1'b1, 8'h33, 2'd3, 1'b1, 1'b0, 8'hB0, 4'b0111, 1'b1},
    {1'b1, 8'hF1, 2'd1, 1'b0, 1'b0, 8'h98, 4'b0111, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic [7:0] a);
    @(negedge clk);
    wrEn = 1'b1; wrData = d; wrAddr = a;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitReady(output int n);
    n = 0;
    while (rdData[7] == 1'b0 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    rstN = 1'b0; wrEn = 1'b0; wrData = '0; wrAddr = '0;
    busyLen = 8'd2; vppOk = 1'b1; protHigh = 1'b0; arrayIn = 8'h5A;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 array mode after reset", rdData, 8'h5A);
    check("R1 locks clear", {4'b0, lockBits}, 8'h00);
    check("R1 master clear", {7'b0, masterLock}, 8'h00);
    wr(8'h70, 8'h00);
    check("R1/R8 status after 70h", rdData, 8'h80);

    // vector table: R2 R4 R5 R6 R7
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][25]) wr(8'h50, 8'h00);
      vppOk    = VEC[i][14];
      protHigh = VEC[i][13];
      wr(8'h60, {6'b0, VEC[i][16:15]});
      wr(VEC[i][24:17], {6'b0, VEC[i][16:15]});
      waitReady(n);
      check($sformatf("R2/R4/R5/R6/R7 vec%0d status", i), rdData, VEC[i][12:5]);
      check($sformatf("R2/R5/R6 vec%0d locks", i), {4'b0, lockBits}, {4'b0, VEC[i][4:1]});
      check($sformatf("R2/R5 vec%0d master", i), {7'b0, masterLock}, {7'b0, VEC[i][0]});
    end
    vppOk = 1'b1; protHigh = 1'b0;

    // R8 array mode, R10 status after setup
    wr(8'hFF, 8'h00);
    check("R8 array after FFh", rdData, 8'h5A);
    wr(8'h50, 8'h00);
    check("R8 clear keeps array mode", rdData, 8'h5A);
    wr(8'h60, 8'h03);
    check("R10 status after 60h", rdData, 8'h80);

    // R3 busy length 3
    busyLen = 8'd3;
    wr(8'h01, 8'h03);
    waitReady(n);
    check("R3 busy cycles len3", 8'(n), 8'd3);
    check("R2 block3 locked", {4'b0, lockBits}, 8'h0F);
    check("R10 status after lock", rdData, 8'h80);

    // R3 busy length 0 acts as 1
    busyLen = 8'd0;
    wr(8'h60, 8'h00);
    wr(8'hF1, 8'h00);
    waitReady(n);
    check("R3 busy cycles len0", 8'(n), 8'd1);

    // R3 writes during busy ignored
    busyLen = 8'd4;
    wr(8'h60, 8'h00);
    wr(8'hF1, 8'h00);
    wr(8'hFF, 8'h00);
    check("R3 still busy after write", {7'b0, rdData[7]}, 8'h00);
    waitReady(n);
    check("R3 FFh during busy ignored", rdData, 8'h80);

    // R9 unknown command
    wr(8'hFF, 8'h00);
    wr(8'h20, 8'h00);
    check("R9 unknown command", rdData, 8'hB0);
    wr(8'h50, 8'h00);
    check("R7 clear status", rdData, 8'h80);
    wr(8'hFF, 8'h00);
    wr(8'h70, 8'h00);
    check("R8 status after 70h", rdData, 8'h80);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule